// File: doc/BRIEF.md
# Page access checker and fault reporter

This block judges a single memory access that has already been translated by a two-level page walk. It receives the attribute bits of the directory entry and the table entry, the kind of access (read, write or instruction fetch), the privilege level of the requester and the virtual address. One cycle later it reports whether the access is allowed or faults.

When an access faults and no earlier fault is still waiting, the block stores the virtual address in a fault-address register. It also stores a packed 4-bit cause code. It then raises an exception request that carries the page-fault vector. The request stays up until software acknowledges it. While the request is pending, later faults are still reported on the response outputs, but they do not overwrite the stored address or cause code.

The block does not build the exception frame or push the cause code onto a stack. A surrounding core does that, using the values held here.

Top module: `pgchk_top`

## Requirements
- R1: Privilege level 3 is a user access. Levels 0, 1 and 2 are supervisor accesses. Bit 2 of the cause code is 1 exactly for user accesses.
- R2: An access to a page that is not present faults with cause bit 0 equal to 0. For a small page, the page is present only when both entries are present. For a large page, only the directory entry's present bit counts.
- R3: A user access of any kind to a present page whose effective user right is 0 faults with cause bit 0 equal to 1.
- R4: A user write to a present page whose effective writable right is 0 faults with cause bit 0 equal to 1. A supervisor write to such a page is allowed.
- R5: For a small page (dir_large=0), the effective rights are the AND of the directory and table bits. For a large page (dir_large=1), the table bits are ignored entirely.
- R6: Cause bit 1 is 1 exactly when the access kind is write (code 01). Cause bit 3 is always 0. Access kinds 00 (read), 10 (fetch) and 11 are all non-writes.
- R7: One cycle after a cycle with req_valid=1, rsp_valid is 1 and exactly one of rsp_allow and rsp_fault is 1. Otherwise rsp_valid is 0.
- R8: A fault taken while no request is pending stores the faulting virtual address (fetches included) and its cause code, and raises exc_req with exc_vector 0x0E. All of these are visible in the same cycle as the response.
- R9: exc_req stays 1 until a cycle with exc_ack=1. It is 0 in the following cycle.
- R10: While exc_req is 1, later faults are still reported on rsp_fault, but fault_addr and fault_code keep their stored values.
- R11: After reset, rsp_valid, rsp_allow, rsp_fault and exc_req are 0, and fault_addr and fault_code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 treated as read |
| req_priv | input | 2 | Privilege level of the requester |
| req_vaddr | input | 32 | Virtual address of the access |
| dir_present | input | 1 | Directory entry present bit |
| dir_writable | input | 1 | Directory entry writable bit |
| dir_user | input | 1 | Directory entry user bit |
| dir_large | input | 1 | Directory entry maps a large page |
| tbl_present | input | 1 | Table entry present bit |
| tbl_writable | input | 1 | Table entry writable bit |
| tbl_user | input | 1 | Table entry user bit |
| exc_ack | input | 1 | Software acknowledge of the exception request |
| rsp_valid | output | 1 | Verdict valid |
| rsp_allow | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access faulted |
| fault_addr | output | 32 | Stored faulting virtual address |
| fault_code | output | 4 | Stored cause code |
| exc_req | output | 1 | Exception request pending |
| exc_vector | output | 8 | Exception vector, 0x0E |

## Verification
A wrong merge of the entry attributes, or a wrong user/supervisor decode, shows up one cycle after the access: rsp_fault takes the wrong value, or a cause code with wrong bits is stored. A faulty pending flag shows in two ways. It can let a second fault overwrite fault_addr in the very next response cycle. Or exc_req can drop before exc_ack, or stay up after it, which is visible within one cycle of the acknowledge. The scoreboard therefore compares the verdict, the stored address, the stored code and the request flag on every response cycle, so that any divergence is caught where it first appears.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_OTHER = 2'b11
   } acc_kind_e;

   // Effective rights after merging the two walk levels
   typedef struct packed {
      logic present;
      logic writable;
      logic user;
   } rights_t;

   // Cause code layout: bit positions are decoded by software
   localparam int unsigned CODE_W      = 4;
   localparam int unsigned CODE_PROT   = 0;
   localparam int unsigned CODE_WRITE  = 1;
   localparam int unsigned CODE_USER   = 2;
   localparam int unsigned CODE_RSVD   = 3;

endpackage

// File: rtl/pgchk_rights.sv
module pgchk_rights #(
   parameter bit LARGE_EN = 1'b1
) (
   input  logic                dir_present,
   input  logic                dir_writable,
   input  logic                dir_user,
   input  logic                dir_large,
   input  logic                tbl_present,
   input  logic                tbl_writable,
   input  logic                tbl_user,
   output pgchk_pkg::rights_t  eff
);
   import pgchk_pkg::*;

   rights_t small_r;
   rights_t large_r;

   always_comb begin
      small_r.present  = dir_present  & tbl_present;
      small_r.writable = dir_writable & tbl_writable;
      small_r.user     = dir_user     & tbl_user;
      large_r.present  = dir_present;
      large_r.writable = dir_writable;
      large_r.user     = dir_user;
   end

   generate
      if (LARGE_EN) begin : g_large
         assign eff = dir_large ? large_r : small_r;
      end else begin : g_small_only
         logic unused_large;
         assign unused_large = dir_large;
         assign eff = small_r;
      end
   endgenerate

endmodule

// File: rtl/pgchk_decide.sv
module pgchk_decide #(
   parameter int unsigned PL_W    = 2,
   parameter int unsigned USER_PL = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              req_valid,
   input  logic [1:0]                        req_kind,
   input  logic [PL_W-1:0]                   req_priv,
   input  pgchk_pkg::rights_t                eff,
   output logic                              cur_fault,
   output logic [pgchk_pkg::CODE_W-1:0]      cur_code
);
   import pgchk_pkg::*;

   logic is_user;
   logic is_write;
   logic prot_viol;

   always_comb begin
      is_user   = (req_priv == PL_W'(USER_PL));
      is_write  = (acc_kind_e'(req_kind) == ACC_WRITE);
      prot_viol = is_user & (~eff.user | (is_write & ~eff.writable));
      cur_fault = ~eff.present | prot_viol;
      cur_code  = '0;
      cur_code[CODE_PROT]  = eff.present;
      cur_code[CODE_WRITE] = is_write;
      cur_code[CODE_USER]  = is_user;
      cur_code[CODE_RSVD]  = 1'b0;
   end

   // R2: a missing page always faults
   p_absent_faults_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !eff.present) |-> cur_fault);

   // R4: supervisor access to a present page never faults
   p_sup_write_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && eff.present && req_priv != PL_W'(USER_PL)) |-> !cur_fault);

endmodule

// File: rtl/pgchk_capture.sv
module pgchk_capture #(
   parameter int unsigned VA_W      = 32,
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned FAULT_VEC = 14
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [VA_W-1:0]               req_vaddr,
   input  logic                          cur_fault,
   input  logic [pgchk_pkg::CODE_W-1:0]  cur_code,
   input  logic                          exc_ack,
   output logic                          rsp_valid,
   output logic                          rsp_allow,
   output logic                          rsp_fault,
   output logic [VA_W-1:0]               fault_addr,
   output logic [pgchk_pkg::CODE_W-1:0]  fault_code,
   output logic                          exc_req,
   output logic [VEC_W-1:0]              exc_vector
);
   import pgchk_pkg::*;

   logic take;
   assign take = req_valid & cur_fault & ~exc_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_allow <= 1'b0;
         rsp_fault <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_allow <= req_valid & ~cur_fault;
         rsp_fault <= req_valid &  cur_fault;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_addr <= '0;
         fault_code <= '0;
      end else if (take) begin
         fault_addr <= req_vaddr;
         fault_code <= cur_code;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       exc_req <= 1'b0;
      else if (take)    exc_req <= 1'b1;
      else if (exc_ack) exc_req <= 1'b0;
   end

   assign exc_vector = VEC_W'(FAULT_VEC);

   // R7: verdict is exclusive and only with a valid response
   p_one_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_allow ^ rsp_fault));
   p_no_stray_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_allow | rsp_fault));
   // R9: request holds until acknowledged, then drops
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && !exc_ack) |=> exc_req);
   p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && exc_ack) |=> !exc_req);
   // R10: stored fault record frozen while pending
   p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> ($stable(fault_addr) && $stable(fault_code)));
   // R6: reserved code bit stays clear
   p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_code[CODE_RSVD] == 1'b0);
   // R8: a raised request comes with a fault verdict
   p_rise_with_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exc_req) |-> rsp_fault);

endmodule

// File: rtl/pgchk_top.sv
module pgchk_top #(
   parameter int unsigned VA_W      = 32,
   parameter int unsigned PL_W      = 2,
   parameter int unsigned USER_PL   = 3,
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned FAULT_VEC = 14,
   parameter bit          LARGE_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_kind,
   input  logic [PL_W-1:0]  req_priv,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic             dir_present,
   input  logic             dir_writable,
   input  logic             dir_user,
   input  logic             dir_large,
   input  logic             tbl_present,
   input  logic             tbl_writable,
   input  logic             tbl_user,
   input  logic             exc_ack,
   output logic             rsp_valid,
   output logic             rsp_allow,
   output logic             rsp_fault,
   output logic [VA_W-1:0]  fault_addr,
   output logic [3:0]       fault_code,
   output logic             exc_req,
   output logic [VEC_W-1:0] exc_vector
);
   import pgchk_pkg::*;

   localparam int unsigned MAX_PL = (1 << PL_W) - 1;

   generate
      if (VA_W < 13)
         $error("pgchk_top: address too narrow for a page offset");
      if (USER_PL > MAX_PL)
         $error("pgchk_top: user level does not fit in privilege field");
      if (FAULT_VEC >= (1 << VEC_W))
         $error("pgchk_top: vector does not fit in vector field");
      if (CODE_W != 4)
         $error("pgchk_top: cause code must be four bits");
   endgenerate

   rights_t            eff;
   logic               cur_fault;
   logic [CODE_W-1:0]  cur_code;

   pgchk_rights #(.LARGE_EN(LARGE_EN)) u_rights (
      .dir_present  (dir_present),
      .dir_writable (dir_writable),
      .dir_user     (dir_user),
      .dir_large    (dir_large),
      .tbl_present  (tbl_present),
      .tbl_writable (tbl_writable),
      .tbl_user     (tbl_user),
      .eff          (eff)
   );

   pgchk_decide #(.PL_W(PL_W), .USER_PL(USER_PL)) u_decide (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .req_priv  (req_priv),
      .eff       (eff),
      .cur_fault (cur_fault),
      .cur_code  (cur_code)
   );

   pgchk_capture #(.VA_W(VA_W), .VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_vaddr  (req_vaddr),
      .cur_fault  (cur_fault),
      .cur_code   (cur_code),
      .exc_ack    (exc_ack),
      .rsp_valid  (rsp_valid),
      .rsp_allow  (rsp_allow),
      .rsp_fault  (rsp_fault),
      .fault_addr (fault_addr),
      .fault_code (fault_code),
      .exc_req    (exc_req),
      .exc_vector (exc_vector)
   );

   // R8: vector constant whenever a request is up
   p_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> (exc_vector == VEC_W'(FAULT_VEC)));

endmodule

// File: tb/test_pgchk_top.sv
module test_pgchk_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'b00;
   logic [1:0]  req_priv = 2'd0;
   logic [31:0] req_vaddr = '0;
   logic        dir_present = 0, dir_writable = 0, dir_user = 0, dir_large = 0;
   logic        tbl_present = 0, tbl_writable = 0, tbl_user = 0;
   logic        exc_ack = 1'b0;
   logic        rsp_valid, rsp_allow, rsp_fault, exc_req;
   logic [31:0] fault_addr;
   logic [3:0]  fault_code;
   logic [7:0]  exc_vector;

   always #2.5 clk = ~clk;

   pgchk_top i_pgchk_top (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_priv(req_priv), .req_vaddr(req_vaddr),
      .dir_present(dir_present), .dir_writable(dir_writable),
      .dir_user(dir_user), .dir_large(dir_large),
      .tbl_present(tbl_present), .tbl_writable(tbl_writable), .tbl_user(tbl_user),
      .exc_ack(exc_ack), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
      .rsp_fault(rsp_fault), .fault_addr(fault_addr), .fault_code(fault_code),
      .exc_req(exc_req), .exc_vector(exc_vector)
   );

   typedef struct {
      string       tag;
      logic        fault;
      logic [31:0] addr;
      logic [3:0]  code;
      logic        pend;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   logic        m_pend = 0;
   logic [31:0] m_addr = '0;
   logic [3:0]  m_code = '0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Driver: one access, expectation computed from the requirements
   task automatic access(string tag, logic [1:0] kind, logic [1:0] pl, logic [31:0] va,
                         logic dp, logic dw, logic du, logic dl,
                         logic tp, logic tw, logic tu);
      exp_t e;
      logic p, w, u, usr, wr, flt;
      p   = dl ? dp : (dp & tp);
      w   = dl ? dw : (dw & tw);
      u   = dl ? du : (du & tu);
      usr = (pl == 2'd3);
      wr  = (kind == 2'b01);
      flt = !p || (usr && !u) || (usr && wr && !w);
      if (flt && !m_pend) begin
         m_pend = 1;
         m_addr = va;
         m_code = {1'b0, usr, wr, p};
      end
      e.tag = tag; e.fault = flt; e.addr = m_addr; e.code = m_code; e.pend = m_pend;
      exp_q.push_back(e);
      req_valid = 1; req_kind = kind; req_priv = pl; req_vaddr = va;
      dir_present = dp; dir_writable = dw; dir_user = du; dir_large = dl;
      tbl_present = tp; tbl_writable = tw; tbl_user = tu;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic ack();
      exc_ack = 1;
      @(negedge clk);
      exc_ack = 0;
      m_pend = 0;
      chk("R9 request cleared after ack", exc_req, 0);
   endtask

   // Monitor: pop and compare on each response
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
               chk("R7 unexpected response", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk({e.tag, " fault"}, rsp_fault, e.fault);
               chk({e.tag, " R7 allow"}, rsp_allow, !e.fault);
               chk({e.tag, " addr"}, fault_addr, e.addr);
               chk({e.tag, " code"}, fault_code, e.code);
               chk({e.tag, " R9 pending"}, exc_req, e.pend);
               if (exc_req) chk({e.tag, " R8 vector"}, exc_vector, 32'h0E);
            end
         end
      end
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 rsp_valid", rsp_valid, 0);
      chk("R11 exc_req", exc_req, 0);
      chk("R11 fault_addr", fault_addr, 0);
      chk("R11 fault_code", fault_code, 0);
      rst_n = 1;
      @(negedge clk);
      // R1 supervisor read, R1 user read on user page
      access("R1 sup read", 2'b00, 2'd0, 32'h0000_1000, 1,1,1,0, 1,1,1);
      access("R1 user read", 2'b00, 2'd3, 32'h0000_2000, 1,1,1,0, 1,1,1);
      // R3 user read, directory forbids user
      access("R3 user no-user", 2'b00, 2'd3, 32'h1234_5678, 1,1,0,0, 1,1,1);
      @(negedge clk);
      chk("R9 still pending", exc_req, 1);
      ack();
      // R2 directory absent, supervisor
      access("R2 dir absent", 2'b00, 2'd1, 32'h0040_0010, 0,1,1,0, 1,1,1);
      ack();
      // R2 table absent, user write: code 0110
      access("R2 tbl absent", 2'b01, 2'd3, 32'h0080_0020, 1,1,1,0, 0,1,1);
      ack();
      // R4 user write to read-only table: code 0111
      access("R4 user write ro", 2'b01, 2'd3, 32'h00C0_0030, 1,1,1,0, 1,0,1);
      ack();
      // R4 supervisor write read-only allowed
      access("R4 sup write ro", 2'b01, 2'd2, 32'h00C0_0040, 1,0,1,0, 1,0,1);
      // R5 large page ignores table bits
      access("R5 large ignores tbl", 2'b01, 2'd3, 32'h0100_0000, 1,1,1,1, 0,0,0);
      // R1 level 2 is supervisor
      access("R1 level2 sup", 2'b00, 2'd2, 32'h0100_1000, 1,1,0,0, 1,1,1);
      // R6 kind 11 is a non-write
      access("R6 kind11 read", 2'b11, 2'd3, 32'h0100_2000, 1,0,1,0, 1,0,1);
      // R8 fetch address captured, large page no user
      access("R8 fetch fault", 2'b10, 2'd3, 32'hDEAD_B000, 1,1,0,1, 1,1,1);
      // R10 second fault while pending does not overwrite
      access("R10 blocked fault", 2'b01, 2'd3, 32'hBEEF_0000, 0,0,0,0, 0,0,0);
      access("R10 allowed while pending", 2'b00, 2'd0, 32'h0000_3000, 1,1,1,0, 1,1,1);
      repeat (3) @(negedge clk);
      chk("R9 held without ack", exc_req, 1);
      chk("R10 addr kept", fault_addr, 32'hDEAD_B000);
      ack();
      // R6 write bit for supervisor absent page: code 0010
      access("R6 sup write absent", 2'b01, 2'd0, 32'h0200_0000, 1,1,1,0, 0,1,1);
      ack();
      repeat (3) @(negedge clk);
      chk("R7 queue drained", exp_q.size(), 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule